// File: doc/BRIEF.md
# Clear-on-read interrupt status register

This block holds one sticky status bit for each of twelve interrupt sources inside a network controller. Each source delivers single-cycle event pulses. A pulse sets the source's bit only when the matching bit of a separate mask input is clear. The mask polarity is therefore inverted: a mask bit of 1 blocks capture.

A register read returns the current bits, and the same read clears every bit. A register write loads the writable bits directly from the write data, whatever the mask holds. Test software uses this to raise or drop individual interrupts. A single level interrupt output stays high while any bit is set.

The bits sit inside a 32-bit register word. Sources 0 to 7 occupy bits 7:0. Sources 8 to 11 occupy bits 13:10. Bits 9:8 and bits 31:14 are reserved. The register sits at offset 0x24 of the controller map, but address decoding happens outside this block. Only the read strobe and the write strobe arrive here.

Top module: `irq_status_reg`

## Requirements
- R1: An event pulse on source i sets its status bit only if maskBits[i] is 0. When maskBits[i] is 1, the pulse leaves the bit unchanged.
- R2: A write (wrStrobe high) loads every writable status bit from wrData at that bit's position on the next edge, regardless of maskBits. A bit written 0 is cleared.
- R3: A read (rdStrobe high, wrStrobe low) clears all status bits on the next edge. The only exception is bits captured from events in the read cycle itself.
- R4: irqOut is a register. After every edge it equals the OR of all status bits held after that same edge. It is 0 while no bit is set.
- R5: Register bits 31:14 and 9:8 always read 0. Values written to them have no effect.
- R6: Source i maps to register bit i for i in 0..7, and to bit i+2 for i in 8..11. This mapping applies to both read data and write data.
- R7: rdData is registered. It shows the status sampled in the read cycle from the edge that ends that cycle onward. It holds that value until the next read.
- R8: If an event arrives in the same cycle as a read, rdData returns the status from before the event. The event's bit remains set after the clear.
- R9: If a write and an event hit the same cycle, the written value wins for every bit.
- R10: After reset, all status bits, rdData and irqOut are 0.
- R11: A set status bit stays set through any number of idle cycles until a read or a write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evtPulse | input | 12 | One-cycle event pulses, one per source |
| maskBits | input | 12 | Per-source mask, 1 blocks capture |
| rdStrobe | input | 1 | Register read, one cycle |
| wrStrobe | input | 1 | Register test write, one cycle |
| wrData | input | 32 | Write data in register bit layout |
| rdData | output | 32 | Registered read data in register bit layout |
| irqOut | output | 1 | Level interrupt, high while any bit is set |

## Verification
Embedded assertions check the following on every cycle:
- No masked source raises a bit.
- A read leaves only bits from same-cycle events.
- A captured event is never lost.
- A write loads its data exactly.
- irqOut tracks the stored bits.
- rdData changes only on a read.

The bench's scenarios are needed for what the assertions cannot see. These are the absolute bit mapping of each source and write position in the register word, the reserved-bit behaviour seen at the read port, and the ordering corner cases (event colliding with a read or a write) judged against independently computed words.

// File: rtl/isr_pkg.sv
package isr_pkg;
  parameter int REG_W   = 32;
  parameter int NUM_SRC = 12;
  parameter int LOW_SRC = 8;   // sources packed from bit 0 upward
  parameter int GAP_W   = 2;   // reserved hole above the low group

  typedef struct packed {
    logic load;     // test write loads status
    logic clear;    // read-clear of status
    logic capture;  // event capture enabled this cycle
    logic latchRd;  // snapshot status into read data
  } isrCtrl_t;

  function automatic int bitPos(input int src);
    return (src < LOW_SRC) ? src : src + GAP_W;
  endfunction

  function automatic logic [REG_W-1:0] expandBits(input logic [NUM_SRC-1:0] s);
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_SRC; i++) w[bitPos(i)] = s[i];
    return w;
  endfunction

  function automatic logic [NUM_SRC-1:0] compactBits(input logic [REG_W-1:0] w);
    logic [NUM_SRC-1:0] s;
    for (int i = 0; i < NUM_SRC; i++) s[i] = w[bitPos(i)];
    return s;
  endfunction
endpackage

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
(
  input  logic     rdStrobe,
  input  logic     wrStrobe,
  output isrCtrl_t ctl
);
  // write has top priority, then event capture, then read-clear
  always_comb begin
    ctl.load    = wrStrobe;
    ctl.capture = ~wrStrobe;
    ctl.clear   = rdStrobe & ~wrStrobe;
    ctl.latchRd = rdStrobe;
  end
endmodule

// File: rtl/isr_datapath.sv
module isr_datapath
  import isr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  isrCtrl_t           ctl,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [NUM_SRC-1:0] maskBits,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] statusNext;
  logic [NUM_SRC-1:0] evtGated;

  assign evtGated = evtPulse & ~maskBits;

  always_comb begin
    statusNext = statusQ;
    if (ctl.clear)   statusNext = '0;
    if (ctl.capture) statusNext = statusNext | evtGated;
    if (ctl.load)    statusNext = compactBits(wrData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      irqOut  <= 1'b0;
      rdData  <= '0;
    end else begin
      statusQ <= statusNext;
      irqOut  <= |statusNext;
      if (ctl.latchRd) rdData <= expandBits(statusQ);
    end
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ((statusQ & ~$past(statusQ) & $past(maskBits)) == '0)); // R1
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (statusQ == compactBits($past(wrData)))); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> ((statusQ & ~$past(evtPulse & ~maskBits)) == '0)); // R3
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|statusQ)); // R4
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (($past(evtPulse & ~maskBits) & ~statusQ) == '0)); // R8
  AST_RD_SNAPSHOT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchRd |=> (rdData == expandBits($past(statusQ)))); // R7
  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchRd |=> $stable(rdData)); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.clear) |=> ((~statusQ & $past(statusQ)) == '0)); // R11
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import isr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [NUM_SRC-1:0] maskBits,
  input  logic               rdStrobe,
  input  logic               wrStrobe,
  input  logic [REG_W-1:0]   wrData,
  output logic [REG_W-1:0]   rdData,
  output logic               irqOut
);
  isrCtrl_t ctl;

  isr_ctrl u_ctrl (
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .ctl      (ctl)
  );

  isr_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .evtPulse (evtPulse),
    .maskBits (maskBits),
    .wrData   (wrData),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/irq_status_reg_tb.sv
module irq_status_reg_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] evtPulse = '0;
  logic [11:0] maskBits = '0;
  logic        rdStrobe = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [31:0] rv;

  localparam logic [31:0] WRITABLE = 32'h0000_3CFF;

  always #2.5 clk = ~clk;

  irq_status_reg u_dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .maskBits(maskBits),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int posOf(input int src);
    return (src < 8) ? src : src + 2;
  endfunction

  // one cycle of stimulus, returns at the following negedge
  task automatic step(input logic [11:0] ev, input logic [11:0] mk, input logic rd,
                      input logic wr, input logic [31:0] wd);
    @(negedge clk);
    evtPulse = ev; maskBits = mk; rdStrobe = rd; wrStrobe = wr; wrData = wd;
    @(negedge clk);
    evtPulse = '0; rdStrobe = 1'b0; wrStrobe = 1'b0; wrData = '0;
  endtask

  task automatic doRead(output logic [31:0] v);
    step('0, '1, 1'b1, 1'b0, '0);
    v = rdData;
  endtask

  initial begin
    #1000000;
    checkCnt++; failCnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rdData", rdData, 32'h0);
    check("R10 irq", {31'h0, irqOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 irq after release", {31'h0, irqOut}, 32'h0);

    // R1 R6 R4 R3: every source, masked and unmasked
    for (int i = 0; i < 12; i++) begin
      for (int m = 0; m < 2; m++) begin
        logic [11:0] mk;
        logic [31:0] exp;
        mk  = (m == 1) ? 12'hFFF : ~(12'h1 << i);
        exp = (m == 1) ? 32'h0 : (32'h1 << posOf(i));
        step(12'h1 << i, mk, 1'b0, 1'b0, '0);
        check("R4 irq after event", {31'h0, irqOut}, {31'h0, (m == 0)});
        doRead(rv);
        check("R1 R6 source bit", rv, exp);
        check("R3 irq after read", {31'h0, irqOut}, 32'h0);
      end
    end

    // R2 R5 R6: write every bit position with mask fully blocking
    for (int b = 0; b < 32; b++) begin
      logic [31:0] exp;
      exp = WRITABLE & (32'h1 << b);
      step('0, 12'hFFF, 1'b0, 1'b1, 32'h1 << b);
      check("R4 irq after write", {31'h0, irqOut}, {31'h0, (exp != 0)});
      doRead(rv);
      check("R2 R5 write position", rv, exp);
    end
    step('0, '1, 1'b0, 1'b1, 32'hFFFF_FFFF);
    doRead(rv);
    check("R5 all ones write", rv, WRITABLE);

    // R2: write zero drops an event-set bit
    step(12'h020, 12'h000, 1'b0, 1'b0, '0);
    step('0, '0, 1'b0, 1'b1, 32'h0);
    check("R2 irq after write zero", {31'h0, irqOut}, 32'h0);
    doRead(rv);
    check("R2 write zero clears", rv, 32'h0);

    // R11: sticky through idle cycles; R3 second read is empty
    step(12'h400, 12'h000, 1'b0, 1'b0, '0);
    repeat (6) step('0, '0, 1'b0, 1'b0, '0);
    check("R11 irq held", {31'h0, irqOut}, 32'h1);
    doRead(rv);
    check("R11 sticky bit", rv, 32'h1 << 12);
    doRead(rv);
    check("R3 cleared after read", rv, 32'h0);

    // R8: event collides with read
    step(12'h001, 12'h000, 1'b0, 1'b0, '0);
    step(12'h002, 12'h000, 1'b1, 1'b0, '0);
    check("R8 read returns pre-event", rdData, 32'h1);
    check("R8 irq stays", {31'h0, irqOut}, 32'h1);
    doRead(rv);
    check("R8 event survives clear", rv, 32'h2);

    // R9: write beats event
    step(12'h008, 12'h000, 1'b0, 1'b1, 32'h0);
    doRead(rv);
    check("R9 write zero beats event", rv, 32'h0);
    step(12'h001, 12'hFFF, 1'b0, 1'b1, 32'h0000_2008);
    doRead(rv);
    check("R9 write value wins", rv, 32'h0000_2008);

    // R7: read data holds while status changes
    step(12'h080, 12'h000, 1'b0, 1'b0, '0);
    doRead(rv);
    step(12'h100, 12'h000, 1'b0, 1'b0, '0);
    step('0, '0, 1'b0, 1'b1, 32'h0000_0C00);
    check("R7 rdData held", rdData, 32'h80);
    doRead(rv);
    check("R7 next read", rv, 32'h0000_0C00);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule